// File: doc/BRIEF.md
# Receive Character Queue with Line-Error Tracking

This block is the buffer between the receive shift register of one asynchronous serial channel and the CPU register interface. The shift register hands over each assembled character as a one-cycle strobe. The strobe carries the data byte and three line-error flags: parity, framing and break. A separate strobe marks each detected start bit. The block queues every character together with its own flags. It presents the oldest byte and a status word to the CPU, and it raises an interrupt request.

The status word has two modes. In per-character mode the flags shown belong to the character at the head of the queue, so software must read status before it reads data. In cumulative mode each flag is sticky. It holds the OR of that flag over every character written into the queue since the last error-clear command, so one integrity check can cover a whole message.

When the queue is full, one more character waits in a single holding stage. It enters the queue as soon as a slot frees. A further start bit that arrives while the holding stage is still blocked discards the held character and sets a sticky overrun flag. Enable, disable, receiver-reset and error-clear commands are one-cycle pulses.

Top module: `rx_err_queue`

## Requirements
- R1: Each queue entry keeps an 8-bit data byte with its parity, framing and break flags. While `q_avail` is high, `q_byte` shows the oldest entry's byte.
- R2: With `blk_mode` low, `st_par`, `st_frm` and `st_brk` show the flags of the oldest entry. They are all 0 when the queue is empty.
- R3: A `rd_pop` pulse removes the oldest entry and its flags when the queue is not empty. It has no effect when the queue is empty. The status outputs are combinational, so observing them changes nothing.
- R4: With `blk_mode` high, each status flag is the OR of that flag over all characters written into the queue since the last `err_clr` pulse. A character written in the same cycle as `err_clr` counts toward the new accumulation.
- R5: A character that completes while the queue is full and nothing is popped goes into the holding stage. The held character is written into the queue, ahead of any newer character, in the first cycle a slot is free.
- R6: A `start_det` pulse while a character is held and no slot frees in that cycle discards the held character and leaves the queue unchanged. `st_ovr` goes high after that clock edge.
- R7: `st_ovr` stays high until an `err_clr` or `rx_reset` pulse. If a set and an `err_clr` fall in the same cycle, the clear wins.
- R8: After an `rx_disable` pulse, which takes effect in its own cycle, no characters are accepted and the held character is lost. Entries already queued can still be popped. An `rx_enable` pulse allows reception from the next cycle on, and `rx_disable` wins over `rx_enable` when both arrive together.
- R9: An `rx_reset` pulse empties the queue and the holding stage, clears all status flags and the interrupt request, and leaves reception disabled. It takes priority over every other input.
- R10: `irq` equals `q_avail` when `irq_on_full` is 0, and equals `q_full` when it is 1.
- R11: The queue depth is the parameter DEPTH, default 8. `q_full` is high exactly when DEPTH entries are stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_enable | input | 1 | Pulse: allow reception from the next cycle |
| rx_disable | input | 1 | Pulse: stop reception and drop the held character |
| rx_reset | input | 1 | Pulse: empty the queue, clear status, disable reception |
| err_clr | input | 1 | Pulse: clear overrun and the cumulative flags |
| blk_mode | input | 1 | 0 = per-character status, 1 = cumulative status |
| irq_on_full | input | 1 | 0 = interrupt on data available, 1 = interrupt on full |
| start_det | input | 1 | Strobe: start bit detected |
| chr_vld | input | 1 | Strobe: character assembled |
| chr_data | input | 8 | Assembled data byte |
| chr_par | input | 1 | Parity error of the assembled character |
| chr_frm | input | 1 | Framing error of the assembled character |
| chr_brk | input | 1 | Break received with the character |
| rd_pop | input | 1 | Pulse: CPU reads the data register |
| q_byte | output | 8 | Oldest data byte |
| q_avail | output | 1 | At least one entry stored |
| q_full | output | 1 | DEPTH entries stored |
| st_par | output | 1 | Parity status |
| st_frm | output | 1 | Framing status |
| st_brk | output | 1 | Break status |
| st_ovr | output | 1 | Sticky overrun |
| irq | output | 1 | Interrupt request |

## Verification
A wrong occupancy count inside the queue shows at once on `q_avail`, `q_full` and `irq`, and it shows again when a pop returns a byte out of order. A wrong holding-stage state is subtler. Its first symptom can come several cycles later: a missing or duplicated byte after the next pop, or an overrun flag that rises on a start bit where it should not. The bench therefore compares every output against an independent model after every clock edge. A flag sticky register that drops early or picks up a flag it should not shows on the next cycle in cumulative mode. In per-character mode the same fault shows only when the mode changes.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
   localparam int NFLAG = 3;
   typedef struct packed {
      logic brk;
      logic frm;
      logic par;
   } rxq_flags_t;
endpackage

// File: rtl/rxq_fifo.sv
module rxq_fifo #(
   parameter int W     = 11,
   parameter int DEPTH = 8
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          clr,
   input  logic                          wr,
   input  logic [W-1:0]                  wdata,
   input  logic                          rd,
   output logic [W-1:0]                  rdata,
   output logic [$clog2(DEPTH+1)-1:0]    count,
   output logic                          empty,
   output logic                          full
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH+1);

   if (DEPTH < 2) begin : g_bad_depth
      $error("rxq_fifo: DEPTH must be at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("rxq_fifo: W must be positive");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wp, rp;
   logic [CW-1:0] cnt;

   function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
      if ((1 << AW) == DEPTH) return p + 1'b1;
      else                    return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
   endfunction

   always_ff @(posedge clk) begin
      if (wr && !clr) mem[wp] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else if (clr) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (wr) wp <= step(wp);
         if (rd) rp <= step(rp);
         case ({wr, rd})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end

   assign rdata = mem[rp];
   assign count = cnt;
   assign empty = (cnt == '0);
   assign full  = (cnt == CW'(DEPTH));

   // R11: no write lands on a full queue unless a slot frees in the same cycle
   p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && !rd && !clr) |-> !full);
   // R3: a pop alone lowers occupancy by exactly one
   p_pop_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && !wr && !clr) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/rxq_status.sv
module rxq_status
   import rxq_pkg::*;
#(
   parameter int NF = NFLAG
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr_all,
   input  logic          err_clr,
   input  logic          push,
   input  logic [NF-1:0] push_flags,
   input  logic [NF-1:0] head_flags,
   input  logic          empty,
   input  logic          full,
   input  logic          blk_mode,
   input  logic          irq_on_full,
   input  logic          ovr_set,
   output logic [NF-1:0] st_flags,
   output logic          st_ovr,
   output logic          irq
);
   if (NF < 1) begin : g_bad_nf
      $error("rxq_status: NF must be positive");
   end

   logic [NF-1:0] stk_q;
   logic          ovr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stk_q <= '0;
         ovr_q <= 1'b0;
      end else if (clr_all) begin
         stk_q <= '0;
         ovr_q <= 1'b0;
      end else begin
         stk_q <= (err_clr ? '0 : stk_q) | (push ? push_flags : '0);
         ovr_q <= err_clr ? 1'b0 : (ovr_q | ovr_set);
      end
   end

   for (genvar i = 0; i < NF; i++) begin : g_flag
      assign st_flags[i] = blk_mode ? stk_q[i] : (!empty && head_flags[i]);
      // R4: a cumulative flag only drops on an error clear or receiver reset
      p_sticky_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(stk_q[i]) |-> $past(err_clr || clr_all));
   end

   assign st_ovr = ovr_q;
   assign irq    = irq_on_full ? full : !empty;

   // R7: overrun persists without a clearing command
   p_ovr_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr_q && !err_clr && !clr_all) |=> ovr_q);
endmodule

// File: rtl/rx_err_queue.sv
module rx_err_queue
   import rxq_pkg::*;
#(
   parameter int DEPTH  = 8,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_enable,
   input  logic              rx_disable,
   input  logic              rx_reset,
   input  logic              err_clr,
   input  logic              blk_mode,
   input  logic              irq_on_full,
   input  logic              start_det,
   input  logic              chr_vld,
   input  logic [DATA_W-1:0] chr_data,
   input  logic              chr_par,
   input  logic              chr_frm,
   input  logic              chr_brk,
   input  logic              rd_pop,
   output logic [DATA_W-1:0] q_byte,
   output logic              q_avail,
   output logic              q_full,
   output logic              st_par,
   output logic              st_frm,
   output logic              st_brk,
   output logic              st_ovr,
   output logic              irq
);
   localparam int EW = DATA_W + NFLAG;
   localparam int CW = $clog2(DEPTH+1);

   if (DATA_W < 1) begin : g_bad_dw
      $error("rx_err_queue: DATA_W must be positive");
   end

   logic          rx_on;
   logic          hold_v;
   logic [EW-1:0] hold_q;
   logic [EW-1:0] in_ent, wr_ent, head_ent;
   logic [CW-1:0] q_cnt;
   logic          f_empty, f_full;
   logic          on_eff, pop, can_push, drain, new_push, new_hold, ovr_set, push;
   logic [NFLAG-1:0] st_vec;

   assign in_ent   = {chr_brk, chr_frm, chr_par, chr_data};
   assign on_eff   = rx_on && !rx_disable;
   assign pop      = rd_pop && !f_empty;
   assign can_push = !f_full || pop;
   assign drain    = on_eff && hold_v && can_push;
   assign new_push = on_eff && chr_vld && can_push && !hold_v;
   assign new_hold = on_eff && chr_vld && !new_push;
   assign ovr_set  = on_eff && start_det && hold_v && !can_push;
   assign push     = drain || new_push;
   assign wr_ent   = drain ? hold_q : in_ent;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_on  <= 1'b0;
         hold_v <= 1'b0;
         hold_q <= '0;
      end else if (rx_reset) begin
         rx_on  <= 1'b0;
         hold_v <= 1'b0;
      end else begin
         if (rx_disable)     rx_on <= 1'b0;
         else if (rx_enable) rx_on <= 1'b1;
         if (!on_eff) begin
            hold_v <= 1'b0;
         end else if (new_hold) begin
            hold_v <= 1'b1;
            hold_q <= in_ent;
         end else if (drain || ovr_set) begin
            hold_v <= 1'b0;
         end
      end
   end

   rxq_fifo #(.W(EW), .DEPTH(DEPTH)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (rx_reset),
      .wr    (push),
      .wdata (wr_ent),
      .rd    (pop),
      .rdata (head_ent),
      .count (q_cnt),
      .empty (f_empty),
      .full  (f_full)
   );

   rxq_status #(.NF(NFLAG)) u_stat (
      .clk         (clk),
      .rst_n       (rst_n),
      .clr_all     (rx_reset),
      .err_clr     (err_clr),
      .push        (push),
      .push_flags  (wr_ent[EW-1:DATA_W]),
      .head_flags  (head_ent[EW-1:DATA_W]),
      .empty       (f_empty),
      .full        (f_full),
      .blk_mode    (blk_mode),
      .irq_on_full (irq_on_full),
      .ovr_set     (ovr_set),
      .st_flags    (st_vec),
      .st_ovr      (st_ovr),
      .irq         (irq)
   );

   assign q_byte  = head_ent[DATA_W-1:0];
   assign q_avail = !f_empty;
   assign q_full  = f_full;
   assign st_par  = st_vec[0];
   assign st_frm  = st_vec[1];
   assign st_brk  = st_vec[2];

   // R6: overrun can only rise after a start bit
   p_ovr_needs_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(st_ovr) |-> $past(start_det));
   // R9: receiver reset leaves an empty queue and quiet status
   p_reset_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rx_reset |=> (!q_avail && !st_ovr && !irq));
   // R8: while disabled and not read, occupancy does not move
   p_disabled_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!rx_on && !rd_pop && !rx_reset) |=> $stable(q_cnt));
   // R5: a held character never coexists with free room once reception runs
   p_hold_drains_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_v && !f_full && on_eff) |-> push);
endmodule

// File: tb/sim_rx_err_queue.sv
module sim_rx_err_queue;
   localparam int CLK_P = 10;
   localparam int DEPTH = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic i_en = 0, i_dis = 0, i_rst = 0, i_err = 0, i_blk = 0, i_sel = 0;
   logic i_start = 0, i_vld = 0, i_par = 0, i_frm = 0, i_brk = 0, i_rd = 0;
   logic [7:0] i_data = '0;
   logic [7:0] q_byte;
   logic q_avail, q_full, st_par, st_frm, st_brk, st_ovr, irq;

   int n_chk = 0;
   int n_fail = 0;
   string cur_req = "R9";
   bit done = 0;

   logic [10:0] mq[$];
   bit          m_hv, m_ovr, m_on;
   logic [10:0] m_hq;
   logic [2:0]  m_stk;

   int p_vld, p_start, p_rd, p_err, p_dis, p_en, p_rst;

   always #(CLK_P/2) clk = ~clk;

   rx_err_queue #(.DEPTH(DEPTH), .DATA_W(8)) u0 (
      .clk(clk), .rst_n(rst_n), .rx_enable(i_en), .rx_disable(i_dis),
      .rx_reset(i_rst), .err_clr(i_err), .blk_mode(i_blk), .irq_on_full(i_sel),
      .start_det(i_start), .chr_vld(i_vld), .chr_data(i_data), .chr_par(i_par),
      .chr_frm(i_frm), .chr_brk(i_brk), .rd_pop(i_rd), .q_byte(q_byte),
      .q_avail(q_avail), .q_full(q_full), .st_par(st_par), .st_frm(st_frm),
      .st_brk(st_brk), .st_ovr(st_ovr), .irq(irq)
   );

   function automatic bit chance(int pct);
      return ($urandom % 100) < pct;
   endfunction

   function automatic logic [2:0] exp_flags();
      if (i_blk) return m_stk;
      if (mq.size() == 0) return 3'b000;
      return mq[0][10:8];
   endfunction

   function automatic logic exp_irq();
      return i_sel ? (mq.size() == DEPTH) : (mq.size() > 0);
   endfunction

   task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
      end
   endtask

   task automatic model_reset();
      mq.delete();
      m_hv = 0; m_ovr = 0; m_on = 0; m_stk = '0; m_hq = '0;
   endtask

   task automatic model_step();
      bit pop, full, canp, on_eff, drain, npush, nhold, oset, push;
      logic [10:0] inw, w;
      if (i_rst) begin
         model_reset();
         return;
      end
      inw    = {i_brk, i_frm, i_par, i_data};
      on_eff = m_on && !i_dis;
      pop    = i_rd && (mq.size() > 0);
      full   = (mq.size() == DEPTH);
      canp   = !full || pop;
      drain  = on_eff && m_hv && canp;
      npush  = on_eff && i_vld && canp && !m_hv;
      nhold  = on_eff && i_vld && !npush;
      oset   = on_eff && i_start && m_hv && !canp;
      push   = drain || npush;
      w      = drain ? m_hq : inw;
      if (pop) void'(mq.pop_front());
      if (push) mq.push_back(w);
      if (!on_eff) m_hv = 0;
      else if (nhold) begin m_hv = 1; m_hq = inw; end
      else if (drain || oset) m_hv = 0;
      m_stk = (i_err ? 3'b000 : m_stk) | (push ? w[10:8] : 3'b000);
      m_ovr = i_err ? 1'b0 : (m_ovr | oset);
      if (i_dis) m_on = 0;
      else if (i_en) m_on = 1;
   endtask

   task automatic check_all();
      chk("q_avail(R1)", q_avail, mq.size() > 0);
      if (mq.size() > 0) chk("q_byte(R1)", q_byte, mq[0][7:0]);
      chk("q_full(R11)", q_full, mq.size() == DEPTH);
      chk(i_blk ? "flags(R4)" : "flags(R2)", {st_brk, st_frm, st_par}, exp_flags());
      chk("st_ovr(R7)", st_ovr, m_ovr);
      chk("irq(R10)", irq, exp_irq());
   endtask

   task automatic cyc();
      @(posedge clk);
      model_step();
      @(negedge clk);
      check_all();
   endtask

   task automatic rand_in();
      i_vld   = chance(p_vld);
      i_start = chance(p_start);
      i_rd    = chance(p_rd);
      i_err   = chance(p_err);
      i_dis   = chance(p_dis);
      i_en    = chance(p_en);
      i_rst   = chance(p_rst);
      i_data  = 8'($urandom);
      i_par   = chance(20);
      i_frm   = chance(15);
      i_brk   = chance(10);
   endtask

   task automatic idle_in();
      i_vld = 0; i_start = 0; i_rd = 0; i_err = 0; i_dis = 0; i_en = 0; i_rst = 0;
   endtask

   task automatic run(string req, int n, int vld, int st, int rd, int er, int ds, int en, int rs);
      cur_req = req;
      p_vld = vld; p_start = st; p_rd = rd; p_err = er; p_dis = ds; p_en = en; p_rst = rs;
      for (int k = 0; k < n; k++) begin
         rand_in();
         cyc();
      end
      idle_in();
   endtask

   initial begin
      void'($urandom(32'd20250));
      model_reset();
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      cur_req = "R9";
      check_all();
      // R9: reset state, all outputs low
      chk("reset q_avail(R9)", q_avail, 0);
      chk("reset irq(R9)", irq, 0);

      // R8: characters before enable are ignored
      cur_req = "R8";
      i_vld = 1; i_data = 8'hA5; cyc(); idle_in();
      chk("no accept while disabled(R8)", q_avail, 0);
      i_en = 1; cyc(); idle_in();

      // R1/R2: directed byte with flags, per-character status
      cur_req = "R2";
      i_vld = 1; i_data = 8'h3C; i_par = 1; i_frm = 0; i_brk = 1; cyc(); idle_in();
      chk("head byte(R1)", q_byte, 8'h3C);
      chk("head flags(R2)", {st_brk, st_frm, st_par}, 3'b101);
      // R3: pop empties, extra pop on empty has no effect
      cur_req = "R3";
      i_rd = 1; cyc(); cyc(); idle_in();
      chk("empty after pops(R3)", q_avail, 0);

      // R5: fill to full, hold one, then pop and see held byte enter in order
      cur_req = "R5";
      for (int k = 0; k < DEPTH + 1; k++) begin
         i_vld = 1; i_data = 8'(8'h10 + k); i_par = 0; i_frm = 0; i_brk = 0; cyc();
      end
      idle_in();
      chk("full with hold(R5)", q_full, 1);
      i_rd = 1; cyc(); idle_in();
      chk("still full after drain(R5)", q_full, 1);
      for (int k = 1; k <= DEPTH; k++) begin
         chk("drain order(R5)", q_byte, 8'(8'h10 + k));
         i_rd = 1; cyc(); idle_in();
      end
      chk("empty after drain(R5)", q_avail, 0);

      // R6: full + hold, start bit discards held and sets overrun
      cur_req = "R6";
      for (int k = 0; k < DEPTH + 1; k++) begin
         i_vld = 1; i_data = 8'(8'h40 + k); cyc();
      end
      idle_in();
      i_start = 1; cyc(); idle_in();
      chk("overrun set(R6)", st_ovr, 1);
      i_rd = 1; cyc(); idle_in();
      chk("held byte lost(R6)", q_full, 0);
      // R7: overrun survives until error clear
      cur_req = "R7";
      cyc();
      chk("overrun sticky(R7)", st_ovr, 1);
      i_err = 1; cyc(); idle_in();
      chk("overrun cleared(R7)", st_ovr, 0);
      i_rst = 1; cyc(); idle_in();
      i_en = 1; cyc(); idle_in();

      run("R1", 400, 45, 10, 35, 2, 0, 0, 0);
      run("R3", 300, 30, 10, 80, 2, 0, 0, 0);
      run("R5", 300, 70, 5, 20, 2, 0, 0, 0);
      run("R6", 300, 80, 40, 10, 3, 0, 0, 0);
      i_blk = 1;
      run("R4", 400, 50, 10, 40, 6, 0, 0, 0);
      run("R7", 300, 70, 40, 20, 8, 0, 0, 0);
      i_blk = 0;
      run("R8", 400, 50, 20, 40, 4, 8, 15, 0);
      i_blk = 1;
      run("R9", 400, 50, 20, 30, 4, 3, 20, 4);
      i_sel = 1;
      run("R10", 400, 60, 20, 30, 4, 2, 20, 2);
      i_blk = 0;
      run("R11", 300, 70, 10, 25, 3, 2, 20, 1);

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule